// File: doc/BRIEF.md
# Coarse Oscillator Band Search by Edge Counting

This block selects a 6-bit coarse capacitor-bank code for an LC oscillator so that the oscillator lands close to its target frequency before the loop starts phase acquisition. It does this by counting edges of a pre-divided oscillator signal during a window of fixed length, which is timed from the reference, and comparing the total with a fixed target. A successive-approximation search settles one code bit per measurement step, starting at the MSB.

The block runs on a clock locked to the reference. One reference period spans `REF_OVS` of its cycles. The divided-reference period (`REF_DIV` reference periods) forms one search step. In the first half of a step the newly applied code settles. In the second half, which lasts `REF_DIV/2` reference periods, two counters tally rising and falling edges of the synchronised oscillator event input. The sum of the two counts is compared with `2*REF_DIV*OSC_DIV`. While a search runs, the block asks the loop to hold the control voltage at mid-rail. That request drops together with a one-cycle done pulse, and the loop may then begin phase acquisition.

Top module: `cband_search`

## Requirements
- R1: After reset, `band_code_o` is 0, `hold_mid_o` is 0 and `done_o` is 0.
- R2: A start request sampled while idle makes `hold_mid_o` 1 on the next cycle, with `band_code_o` equal to the MSB-only trial value (binary 100000).
- R3: `hold_mid_o` stays 1 for exactly `CODE_W*REF_DIV*REF_OVS` cycles (6144 with defaults) and falls in the same cycle that `done_o` rises.
- R4: `done_o` is high for exactly one cycle per search.
- R5: Each step counts, over its last `REF_DIV*REF_OVS/2` cycles, both the rising and falling edges of `osc_evt_i` after a two-flop synchroniser. The sum is compared with the target `2*REF_DIV*OSC_DIV` (256 with defaults).
- R6: A trial bit is kept (1 = more capacitance, lower frequency) only when the summed count is strictly above the target. A count equal to or below the target clears the bit.
- R7: Bits are decided one per step from MSB to LSB, and during a search `band_code_o` changes only at step boundaries. For a count that falls as the code rises, the result is the largest code whose count exceeds the target.
- R8: A start request during a search is ignored: the duration and the result are unchanged.
- R9: While idle and without a start request, `band_code_o` holds its last result whatever `osc_evt_i` does.
- R10: If every code counts above the target the result is 63. If no code does, the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `REF_OVS` cycles per reference period |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Search request, sampled only while idle |
| osc_evt_i | input | 1 | Pre-divided oscillator signal, asynchronous |
| band_code_o | output | CODE_W | Coarse capacitor-bank code |
| hold_mid_o | output | 1 | Request to hold the control voltage at mid-rail |
| done_o | output | 1 | One-cycle pulse at the end of a search |

## Verification
The bench builds the block with its default values: a 6-bit code, reference division 32, oscillator division 4 and 32 clock cycles per reference period. This gives a 512-cycle counting window and a target of 256. The oscillator model is a phase accumulator whose increment falls linearly with the code. Its increments are multiples of 64, so each window sees an exact edge total, one count per code step. Every code boundary is therefore within reach: counts equal to the target, one count either side of it, the all-above and all-below extremes, a restart request in mid-search, and a reset in mid-search.

// File: rtl/cband_pkg.sv
package cband_pkg;
  typedef enum logic {
    SRCH_IDLE = 1'b0,
    SRCH_RUN  = 1'b1
  } srch_state_e;
endpackage

// File: rtl/cband_sync_edge.sv
module cband_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cband_edge_tally.sv
module cband_edge_tally #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         pulse_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_o <= '0;
    else if (!en_i)   cnt_o <= '0;
    else if (pulse_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/cband_sar_ctrl.sv
module cband_sar_ctrl
  import cband_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int STEP   = 1024,
  parameter int SUM_W  = 11,
  parameter int TARGET = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SUM_W-1:0]  total_i,
  output logic [CODE_W-1:0] code_o,
  output logic              hold_o,
  output logic              done_o,
  output logic              win_o
);
  localparam int HALF  = STEP / 2;
  localparam int PC_W  = $clog2(STEP);
  localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  srch_state_e       state_q;
  logic [PC_W-1:0]   pc_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CODE_W-1:0] code_q, code_nxt;
  logic              done_q;
  logic              last, over;

  assign last  = (pc_q == PC_W'(STEP - 1));
  assign over  = (32'(total_i) > 32'(TARGET));
  assign win_o = (state_q == SRCH_RUN) && (pc_q >= PC_W'(HALF));

  always_comb begin
    code_nxt = code_q;
    code_nxt[bit_q] = over;
    if (bit_q != '0) code_nxt[bit_q - BIT_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRCH_IDLE;
      pc_q    <= '0;
      bit_q   <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == SRCH_IDLE) begin
        if (start_i) begin
          state_q <= SRCH_RUN;
          pc_q    <= '0;
          bit_q   <= BIT_W'(CODE_W - 1);
          code_q  <= {1'b1, {(CODE_W-1){1'b0}}};
        end
      end else begin
        pc_q <= last ? '0 : pc_q + PC_W'(1);
        if (last) begin
          code_q <= code_nxt;
          if (bit_q == '0) begin
            state_q <= SRCH_IDLE;
            done_q  <= 1'b1;
          end else begin
            bit_q <= bit_q - BIT_W'(1);
          end
        end
      end
    end
  end

  assign code_o = code_q;
  assign hold_o = (state_q == SRCH_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/cband_search.sv
module cband_search #(
  parameter int CODE_W  = 6,
  parameter int REF_DIV = 32,
  parameter int OSC_DIV = 4,
  parameter int REF_OVS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              osc_evt_i,
  output logic [CODE_W-1:0] band_code_o,
  output logic              hold_mid_o,
  output logic              done_o
);
  localparam int STEP   = REF_DIV * REF_OVS;
  localparam int HALF   = STEP / 2;
  localparam int CNT_W  = $clog2(HALF + 1);
  localparam int SUM_W  = CNT_W + 1;
  localparam int TARGET = 2 * REF_DIV * OSC_DIV;

  logic             rise, fall, win;
  logic [1:0]       pulse;
  logic [CNT_W-1:0] cnt [2];
  logic [SUM_W-1:0] total;

  cband_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(osc_evt_i),
    .rise_o(rise), .fall_o(fall)
  );

  assign pulse = {fall, rise};

  for (genvar g = 0; g < 2; g++) begin : g_tally
    cband_edge_tally #(.W(CNT_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .en_i(win),
      .pulse_i(pulse[g]), .cnt_o(cnt[g])
    );
  end

  assign total = SUM_W'(cnt[0]) + SUM_W'(cnt[1])
               + SUM_W'(rise & win) + SUM_W'(fall & win);

  cband_sar_ctrl #(
    .CODE_W(CODE_W), .STEP(STEP), .SUM_W(SUM_W), .TARGET(TARGET)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_i(total),
    .code_o(band_code_o), .hold_o(hold_mid_o), .done_o(done_o), .win_o(win)
  );
endmodule

// File: rtl/cband_search_chk.sv
module cband_search_chk #(
  parameter int CODE_W  = 6,
  parameter int REF_DIV = 32,
  parameter int REF_OVS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CODE_W-1:0] band_code_o,
  input logic              hold_mid_o,
  input logic              done_o
);
  localparam int STEP    = REF_DIV * REF_OVS;
  localparam int RUN_LEN = CODE_W * STEP;
  localparam int RC_W    = $clog2(RUN_LEN + 2) + 1;

  logic [RC_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_cnt <= '0;
    else if (hold_mid_o) run_cnt <= run_cnt + RC_W'(1);
    else                 run_cnt <= '0;
  end

  assert_first_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_mid_o) |-> (band_code_o == {1'b1, {(CODE_W-1){1'b0}}}));

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_mid_o) |-> $past(start_i));

  assert_release_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_mid_o) |-> done_o);

  assert_run_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_mid_o) |-> (32'(run_cnt) == 32'(RUN_LEN)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_step_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_mid_o && !$stable(band_code_o)) |-> ((32'(run_cnt) % 32'(STEP)) == 0));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_mid_o && !start_i) |=> $stable(band_code_o));
endmodule

bind cband_search cband_search_chk #(
  .CODE_W(CODE_W), .REF_DIV(REF_DIV), .REF_OVS(REF_OVS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .band_code_o(band_code_o),
  .hold_mid_o(hold_mid_o), .done_o(done_o)
);

// File: tb/cband_search_tb.sv
module cband_search_tb;
  localparam int CODE_W  = 6;
  localparam int RUN_LEN = 6 * 32 * 32;
  localparam int MSB     = 32;
  localparam int NV      = 11;
  // each entry: oscillator base B0, expected code. Count(c) = B0 - c, target 256,
  // so the result is the largest c with B0 - c > 256, clamped to 0..63.
  localparam int VEC [NV][2] = '{
    '{200, 0}, '{256, 0}, '{257, 0}, '{258, 1}, '{270, 13}, '{288, 31},
    '{289, 32}, '{290, 33}, '{319, 62}, '{320, 63}, '{400, 63}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic osc_evt;
  logic [CODE_W-1:0] code;
  logic hold, done;

  int errors = 0;
  int checks = 0;
  int b0_q = 200;
  int cyc = 0;
  logic [15:0] acc = '0;

  always #5 clk = ~clk;

  cband_search u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .osc_evt_i(osc_evt),
    .band_code_o(code), .hold_mid_o(hold), .done_o(done)
  );

  // oscillator model: rate falls as the code adds capacitance
  always @(negedge clk) begin
    int inc;
    inc = b0_q - int'(code);
    if (inc < 0) inc = 0;
    acc <= acc + 16'(64 * inc);
  end
  assign osc_evt = acc[15];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic run_search(input int b0, input int exp_code, input int restart_at);
    int n;
    b0_q = b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(hold == 1'b1, "R2 hold", int'(hold), 1);
    chk(int'(code) == MSB, "R2 first trial", int'(code), MSB);
    n = 1;
    while (!done && n < RUN_LEN + 50) begin
      @(negedge clk);
      n++;
      start = (n == restart_at);
    end
    start = 1'b0;
    chk(n == RUN_LEN + 1, "R3 search length", n, RUN_LEN + 1);
    chk(hold == 1'b0, "R3 hold released", int'(hold), 0);
    chk(int'(code) == exp_code, "R6/R7/R10 code", int'(code), exp_code);
    @(negedge clk);
    chk(done == 1'b0, "R4 done width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(code) == 0, "R1 code", int'(code), 0);
    chk(hold == 1'b0, "R1 hold", int'(hold), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 R6 R7 R10: table walk across boundaries and extremes
    for (int i = 0; i < NV; i++) run_search(VEC[i][0], VEC[i][1], 0);

    // R8: restart request inside the second step is ignored
    run_search(290, 33, 2000);

    // R9: idle with changing oscillator rate, no start
    b0_q = 200;
    repeat (3000) @(negedge clk);
    chk(int'(code) == 33, "R9 idle hold", int'(code), 33);
    chk(hold == 1'b0, "R9 idle no hold", int'(hold), 0);

    // R1: reset in mid-search returns to the reset state
    b0_q = 300;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (1500) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(int'(code) == 0, "R1 mid reset code", int'(code), 0);
    chk(hold == 1'b0, "R1 mid reset hold", int'(hold), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_search(300, 43, 0);

    finish_run();
  end
endmodule